// File: doc/BRIEF.md
# Two-Road Demand-Switched Traffic Light Controller

This block drives the green lamps at a crossing of a north-south road and an east-west road. Exactly one road is green at any moment. An external interval timer supplies a one-cycle step pulse at the end of each green interval, nominally every 30 seconds. On that pulse the controller looks at the car sensor of the road that is currently red. If a car is waiting there, the green moves to that road. If not, the current road keeps its green for one more full interval.

The state is a single bit: 0 means north-south green and 1 means east-west green. On a step pulse the next state is (not state and east-west car) or (state and not north-south car). Each lamp output is 1 for green and 0 for red. The lamps come straight from the state bit, so both roads can never be green together. Yellow phases, pedestrian requests and the interval timer itself are outside this block.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in north-south green: green_ns=1 and green_ew=0 on the first falling edge after the reset edge.
- R2: At every cycle outside reset, exactly one of green_ns and green_ew is 1.
- R3: On any clock edge where step_en is 0, the lamps keep their values, whatever the car sensors show.
- R4: With north-south green, a step edge where car_ew=1 switches the lamps to east-west green (green_ns=0, green_ew=1), whatever car_ns shows.
- R5: With north-south green, a step edge where car_ew=0 keeps north-south green, whatever car_ns shows.
- R6: With east-west green, a step edge where car_ns=1 switches the lamps to north-south green, whatever car_ew shows.
- R7: With east-west green, a step edge where car_ns=0 keeps east-west green, whatever car_ew shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | One-cycle pulse marking the end of a green interval |
| car_ns | input | 1 | A car is waiting on the north-south road |
| car_ew | input | 1 | A car is waiting on the east-west road |
| green_ns | output | 1 | North-south lamp: 1 green, 0 red |
| green_ew | output | 1 | East-west lamp: 1 green, 0 red |

## Verification
The embedded properties check four things on every cycle: one green at a time, no change without a step pulse, each of the four transition rules on step edges, and the state right after reset. Only the bench scenarios show the behaviour at the ports. The sweeps drive every combination of step pulse and sensor values from both green states. They show that the sensor of the road already green never affects the decision, and that a reset in the middle of a run returns the lamps to north-south green.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

    // Which road currently holds the green; the bit value is the state encoding.
    typedef enum logic {
        GO_NS = 1'b0,
        GO_EW = 1'b1
    } road_t;

    typedef struct packed {
        logic ns;
        logic ew;
    } lamps_t;

    // Decision taken at the end of an interval: move only when the red road has a car.
    function automatic road_t next_road(road_t cur, logic wait_ns, logic wait_ew);
        road_t nxt;
        if (cur == GO_NS) begin
            nxt = wait_ew ? GO_EW : GO_NS;
        end else begin
            nxt = wait_ns ? GO_NS : GO_EW;
        end
        return nxt;
    endfunction

    function automatic lamps_t lamps_for(road_t cur);
        lamps_t l;
        l.ns = (cur == GO_NS);
        l.ew = (cur == GO_EW);
        return l;
    endfunction

endpackage

// File: rtl/xroad_phase.sv
module xroad_phase
    import xroad_pkg::*;
#(
    parameter road_t HOME_ROAD = GO_NS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step_en,
    input  logic  car_ns,
    input  logic  car_ew,
    output road_t phase_o
);

    road_t phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= HOME_ROAD;
        end else if (step_en) begin
            phase_q <= next_road(phase_q, car_ns, car_ew);
        end
    end

    assign phase_o = phase_q;

    // R3
    hold_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(phase_q));

    // R4
    ns_to_ew_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && phase_q == GO_NS && car_ew) |=> (phase_q == GO_EW));

    // R5
    ns_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && phase_q == GO_NS && !car_ew) |=> (phase_q == GO_NS));

    // R6
    ew_to_ns_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && phase_q == GO_EW && car_ns) |=> (phase_q == GO_NS));

    // R7
    ew_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && phase_q == GO_EW && !car_ns) |=> (phase_q == GO_EW));

endmodule

// File: rtl/xroad_lamps.sv
module xroad_lamps
    import xroad_pkg::*;
(
    input  road_t  phase_i,
    output lamps_t lamps_o
);

    always_comb begin
        lamps_o = lamps_for(phase_i);
    end

endmodule

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl
    import xroad_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic car_ns,
    input  logic car_ew,
    output logic green_ns,
    output logic green_ew
);

    road_t  phase;
    lamps_t lamps;

    xroad_phase #(
        .HOME_ROAD(GO_NS)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .car_ns  (car_ns),
        .car_ew  (car_ew),
        .phase_o (phase)
    );

    xroad_lamps u_lamps (
        .phase_i (phase),
        .lamps_o (lamps)
    );

    assign green_ns = lamps.ns;
    assign green_ew = lamps.ew;

    // R2
    one_green_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({green_ns, green_ew}) == 1);

    // R1
    reset_home_chk: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (green_ns && !green_ew));

endmodule

// File: tb/xroad_signal_ctrl_tb.sv
`timescale 1ns/1ps
module xroad_signal_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic car_ns = 1'b0;
    logic car_ew = 1'b0;
    logic green_ns;
    logic green_ew;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic exp_ew = 1'b0;   // bench model: 0 north-south green, 1 east-west green

    always #2 clk = ~clk;

    xroad_signal_ctrl u_dut (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .car_ns   (car_ns),
        .car_ew   (car_ew),
        .green_ns (green_ns),
        .green_ew (green_ew)
    );

    task automatic check_lamps(input string tag);
        total++;
        if (green_ns !== !exp_ew || green_ew !== exp_ew) begin
            bad++;
            $display("FAIL %s: got ns=%b ew=%b expected ns=%b ew=%b",
                     tag, green_ns, green_ew, !exp_ew, exp_ew);
        end
        total++;
        if ((green_ns ^ green_ew) !== 1'b1) begin
            bad++;
            $display("FAIL R2: got ns=%b ew=%b expected exactly one green",
                     green_ns, green_ew);
        end
    endtask

    // Drive one cycle at the falling edge, then check after the next falling edge.
    task automatic apply(input logic en, input logic ns, input logic ew);
        string tag;
        step_en = en;
        car_ns  = ns;
        car_ew  = ew;
        if (!en)                tag = "R3";
        else if (!exp_ew && ew) tag = "R4";
        else if (!exp_ew)       tag = "R5";
        else if (ns)            tag = "R6";
        else                    tag = "R7";
        @(negedge clk);
        if (en) begin
            exp_ew = exp_ew ? !ns : ew;
        end
        step_en = 1'b0;
        check_lamps(tag);
    endtask

    task automatic force_to(input logic want_ew);
        if (exp_ew != want_ew) begin
            apply(1'b1, !want_ew ? 1'b1 : 1'b0, want_ew);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_ew = 1'b0;
        check_lamps("R1");

        for (int rnd = 0; rnd < 3; rnd++) begin
            for (int st = 0; st < 2; st++) begin
                for (int combo = 0; combo < 8; combo++) begin
                    force_to(st[0]);
                    apply(combo[2], combo[1], combo[0]);
                end
            end
        end

        // Several idle cycles with both sensors set: nothing may move (R3).
        force_to(1'b1);
        for (int i = 0; i < 5; i++) apply(1'b0, 1'b1, 1'b1);
        force_to(1'b0);
        for (int i = 0; i < 5; i++) apply(1'b0, 1'b1, 1'b1);

        // Mid-run reset from east-west green (R1).
        force_to(1'b1);
        rst = 1'b1;
        car_ew = 1'b1;
        step_en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step_en = 1'b0;
        exp_ew = 1'b0;
        check_lamps("R1");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule